// File: doc/BRIEF.md
# ROM Integrity Check Sequencer

At boot this block walks the data area of a ROM through a single read port and streams every word to an external hash engine. It then takes the 256-bit digest the engine returns and compares it word by word against the expected digest stored in the eight highest ROM words. It reports completion and a pass/fail verdict to the power manager, hands the digest to the key manager, and passes ROM access to the system bus.

Control runs on a sparsely encoded state machine. The machine moves forward only on done events from its address counter, from the hash engine and from its digest comparator. An event that comes at the wrong moment, a local escalation, or an address counter that leaves the top-of-ROM index after handover traps the machine in an invalid state and raises a fatal alert. That alert stays set until reset.

Top module: `rom_check_seq`

## Requirements
- R1: While reset is applied and straight after its release, `pm_done_o` and `pm_good_o` read 4'b0101 (false), and `km_valid_o`, `bus_sel_o`, `alert_o` and `hash_valid_o` are 0.
- R2: The ROM words at indices 0 to ROM_WORDS-9 are sent to the hash engine once each, in ascending order. Each 32-bit ROM word fills bits 31:0 of `hash_data_o`, and the upper bits are zero.
- R3: `hash_last_o` is 1 only on the word at index ROM_WORDS-9. `hash_strb_o` is always zero.
- R4: While `hash_valid_o` is 1 and `hash_ready_i` is 0, the valid flag, the data and the last flag stay unchanged into the next cycle.
- R5: A `hash_done_i` pulse that arrives after the last word has been accepted captures the digest as `hash_share0_i ^ hash_share1_i`. At completion `km_valid_o` goes to 1 and `km_digest_o` shows that value. Both then stay constant until reset.
- R6: Digest bits 32i+31:32i are compared with ROM word ROM_WORDS-8+i for i = 0 to 7. `pm_good_o` reads 4'b1010 (true) if all eight words match and 4'b0101 otherwise.
- R7: `pm_done_o` changes from 4'b0101 to 4'b1010 at completion and holds there until reset, unless escalation arrives. `pm_good_o` is constant while done is true. `bus_sel_o` is 1 exactly while done is true. A `hash_done_i` pulse after completion changes nothing.
- R8: A `hash_done_i` pulse while the words are still being read or streamed sets `alert_o` at the next clock edge. After that, `hash_valid_o` stays 0 and `pm_done_o` never reads true.
- R9: A cycle of `esc_i` sets `alert_o` at the next clock edge. After that, `hash_valid_o` is 0 and `pm_done_o` reads false.
- R10: Once set, `alert_o` stays 1 until reset.
- R11: `hash_err_i` has no effect on any output.
- R12: ROM reads are issued with `rom_req_o` and `rom_addr_o`. The data is taken from `rom_rdata_i` in the cycle after the request, and the ROM must hold it there until its next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| esc_i | input | 1 | Local escalation |
| rom_req_o | output | 1 | ROM read request |
| rom_addr_o | output | AW | ROM word address |
| rom_rdata_i | input | DW | ROM read data, one cycle after the request |
| hash_valid_o | output | 1 | Hash word valid |
| hash_data_o | output | HW | Hash word |
| hash_strb_o | output | HW/8 | Byte strobes (always zero) |
| hash_last_o | output | 1 | Final hash word |
| hash_ready_i | input | 1 | Hash engine accepts the word |
| hash_done_i | input | 1 | Digest available |
| hash_share0_i | input | 256 | Digest share 0 |
| hash_share1_i | input | 256 | Digest share 1 |
| hash_err_i | input | 1 | Hash error (ignored) |
| pm_done_o | output | 4 | Completion, multi-bit encoded |
| pm_good_o | output | 4 | Verdict, multi-bit encoded |
| km_valid_o | output | 1 | Digest valid for the key manager |
| km_digest_o | output | 256 | Captured digest |
| bus_sel_o | output | 1 | ROM access handed to the bus |
| alert_o | output | 1 | Sticky fatal alert |

## Verification
The assertions assume the ROM delivers read data in the cycle after a request and holds it until the next read. They also assume the hash engine sends exactly one `hash_done_i` pulse per run after the final word, apart from deliberate misuse. The bench models the ROM as a registered array that updates only on a request. Its hash model drives a pseudo-random ready pattern and gives a single done pulse a few cycles after the last handshake. Early done pulses, pulses after completion and escalation are injected only in the runs that test those faults.

// File: rtl/romchk_pkg.sv
package romchk_pkg;

   // Sparse state codes, pairwise Hamming distance of at least three
   typedef enum logic [5:0] {
      S_READ    = 6'b000111,
      S_SEND    = 6'b011001,
      S_WAITH   = 6'b101010,
      S_CREAD   = 6'b110100,
      S_CCHK    = 6'b111111,
      S_DONE    = 6'b100001,
      S_INVALID = 6'b010010
   } seq_state_e;

   localparam logic [3:0] MB_TRUE  = 4'b1010;
   localparam logic [3:0] MB_FALSE = 4'b0101;

endpackage

// File: rtl/romchk_addr_ctr.sv
module romchk_addr_ctr #(
   parameter int ROM_WORDS = 64,
   parameter int DIG_WORDS = 8,
   localparam int AW = $clog2(ROM_WORDS)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          inc_i,
   input  logic          load_cmp_i,
   output logic [AW-1:0] addr_o,
   output logic          at_data_last_o,
   output logic          at_top_o
);
   localparam logic [AW-1:0] DATA_LAST = AW'(ROM_WORDS - DIG_WORDS - 1);
   localparam logic [AW-1:0] CMP_BASE  = AW'(ROM_WORDS - DIG_WORDS);
   localparam logic [AW-1:0] TOP_IDX   = AW'(ROM_WORDS - 1);

   logic [AW-1:0] addr_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         addr_q <= '0;
      else if (load_cmp_i) addr_q <= CMP_BASE;
      else if (inc_i)      addr_q <= addr_q + 1'b1;
   end

   assign addr_o         = addr_q;
   assign at_data_last_o = (addr_q == DATA_LAST);
   assign at_top_o       = (addr_q == TOP_IDX);

   // R12
   ctr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inc_i && !load_cmp_i) |=> (addr_q == $past(addr_q) + 1'b1));
endmodule

// File: rtl/romchk_digest_cmp.sv
module romchk_digest_cmp #(
   parameter int DW        = 32,
   parameter int DIG_WORDS = 8,
   localparam int IW = $clog2(DIG_WORDS),
   localparam int DIG_W = DW * DIG_WORDS
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             chk_i,
   input  logic [DW-1:0]    rdata_i,
   input  logic [DIG_W-1:0] digest_i,
   output logic             last_word_o,
   output logic             mismatch_o
);
   logic [IW-1:0] idx_q;
   logic          mism_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         idx_q  <= '0;
         mism_q <= 1'b0;
      end else if (chk_i) begin
         mism_q <= mism_q | (rdata_i != digest_i[idx_q*DW +: DW]);
         if (!last_word_o) idx_q <= idx_q + 1'b1;
      end
   end

   assign last_word_o = (idx_q == IW'(DIG_WORDS - 1));
   assign mismatch_o  = mism_q;

   // R6
   mism_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mism_q |=> mism_q);
endmodule

// File: rtl/rom_check_seq.sv
module rom_check_seq
   import romchk_pkg::*;
#(
   parameter int ROM_WORDS = 64,
   parameter int DW        = 32,
   parameter int HW        = 64,
   parameter int DIG_WORDS = 8
) (
   input  logic                         clk_i,
   input  logic                         rst_ni,
   input  logic                         esc_i,
   output logic                         rom_req_o,
   output logic [$clog2(ROM_WORDS)-1:0] rom_addr_o,
   input  logic [DW-1:0]                rom_rdata_i,
   output logic                         hash_valid_o,
   output logic [HW-1:0]                hash_data_o,
   output logic [HW/8-1:0]              hash_strb_o,
   output logic                         hash_last_o,
   input  logic                         hash_ready_i,
   input  logic                         hash_done_i,
   input  logic [DW*DIG_WORDS-1:0]      hash_share0_i,
   input  logic [DW*DIG_WORDS-1:0]      hash_share1_i,
   input  logic                         hash_err_i,
   output logic [3:0]                   pm_done_o,
   output logic [3:0]                   pm_good_o,
   output logic                         km_valid_o,
   output logic [DW*DIG_WORDS-1:0]      km_digest_o,
   output logic                         bus_sel_o,
   output logic                         alert_o
);
   localparam int AW    = $clog2(ROM_WORDS);
   localparam int DIG_W = DW * DIG_WORDS;

   initial begin : param_chk
      assert (DW <= HW) else $error("ROM word wider than hash word");
      assert (HW % 8 == 0) else $error("hash word not byte aligned");
      assert (ROM_WORDS > DIG_WORDS + 1) else $error("ROM too small");
      assert (DIG_WORDS > 1) else $error("digest needs two or more words");
   end

   seq_state_e    state_q, state_d;
   logic [AW-1:0] addr;
   logic          at_data_last, at_top, cmp_last, mismatch;
   logic          inc, load_cmp, chk, cap;
   logic [DIG_W-1:0] dig_q;
   logic          alert_q;

   romchk_addr_ctr #(.ROM_WORDS(ROM_WORDS), .DIG_WORDS(DIG_WORDS)) u_ctr (
      .clk_i, .rst_ni, .inc_i(inc), .load_cmp_i(load_cmp),
      .addr_o(addr), .at_data_last_o(at_data_last), .at_top_o(at_top));

   romchk_digest_cmp #(.DW(DW), .DIG_WORDS(DIG_WORDS)) u_cmp (
      .clk_i, .rst_ni, .chk_i(chk), .rdata_i(rom_rdata_i), .digest_i(dig_q),
      .last_word_o(cmp_last), .mismatch_o(mismatch));

   always_comb begin
      state_d  = state_q;
      inc      = 1'b0;
      load_cmp = 1'b0;
      chk      = 1'b0;
      cap      = 1'b0;
      unique case (state_q)
         S_READ:  state_d = hash_done_i ? S_INVALID : S_SEND;
         S_SEND: begin
            if (hash_done_i) state_d = S_INVALID;
            else if (hash_ready_i) begin
               if (at_data_last) state_d = S_WAITH;
               else begin
                  inc     = 1'b1;
                  state_d = S_READ;
               end
            end
         end
         S_WAITH: begin
            if (hash_done_i) begin
               cap      = 1'b1;
               load_cmp = 1'b1;
               state_d  = S_CREAD;
            end
         end
         S_CREAD: state_d = hash_done_i ? S_INVALID : S_CCHK;
         S_CCHK: begin
            chk = 1'b1;
            if (hash_done_i || (cmp_last != at_top)) state_d = S_INVALID;
            else if (cmp_last) state_d = S_DONE;
            else begin
               inc     = 1'b1;
               state_d = S_CREAD;
            end
         end
         S_DONE:  if (!at_top) state_d = S_INVALID;
         default: state_d = S_INVALID;
      endcase
      if (esc_i) state_d = S_INVALID;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= S_READ;
         alert_q <= 1'b0;
         dig_q   <= '0;
      end else begin
         state_q <= state_d;
         alert_q <= alert_q | (state_d == S_INVALID);
         if (cap) dig_q <= hash_share0_i ^ hash_share1_i;
      end
   end

   generate
      if (HW > DW) begin : g_pad
         assign hash_data_o = {{(HW-DW){1'b0}}, rom_rdata_i};
      end else begin : g_flat
         assign hash_data_o = rom_rdata_i;
      end
   endgenerate

   assign rom_req_o    = (state_q == S_READ) || (state_q == S_CREAD);
   assign rom_addr_o   = addr;
   assign hash_valid_o = (state_q == S_SEND);
   assign hash_last_o  = (state_q == S_SEND) && at_data_last;
   assign hash_strb_o  = '0;
   assign pm_done_o    = (state_q == S_DONE) ? MB_TRUE : MB_FALSE;
   assign pm_good_o    = ((state_q == S_DONE) && !mismatch) ? MB_TRUE : MB_FALSE;
   assign km_valid_o   = (state_q == S_DONE);
   assign km_digest_o  = dig_q;
   assign bus_sel_o    = (state_q == S_DONE);
   assign alert_o      = alert_q;

   // R4
   hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hash_valid_o && !hash_ready_i && !hash_done_i && !esc_i)
      |=> (hash_valid_o && $stable(hash_data_o) && $stable(hash_last_o)));
   // R7
   done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pm_done_o == MB_TRUE && !esc_i) |=> (pm_done_o == MB_TRUE));
   // R7
   good_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pm_done_o == MB_TRUE && !esc_i) |=> $stable(pm_good_o));
   // R5
   digest_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      km_valid_o |=> $stable(km_digest_o));
   // R9
   esc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      esc_i |=> (alert_o && pm_done_o == MB_FALSE));
   // R10
   alert_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      alert_o |=> alert_o);
   // R8
   early_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hash_done_i && hash_valid_o) |=> (alert_o && !hash_valid_o));
   // R11
   err_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hash_err_i && state_q == S_WAITH && !hash_done_i && !esc_i)
      |=> (state_q == S_WAITH));
   // R3
   last_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hash_last_o && hash_ready_i && !hash_done_i && !esc_i) |=> !hash_valid_o);
endmodule

// File: tb/rom_check_seq_tb_top.sv
module rom_check_seq_tb_top;
   localparam int CLK_P     = 10;
   localparam int ROM_WORDS = 64;
   localparam int NDATA     = ROM_WORDS - 8;
   localparam int AW        = $clog2(ROM_WORDS);
   localparam logic [3:0] T4 = 4'b1010;
   localparam logic [3:0] F4 = 4'b0101;

   logic clk = 1'b0, rst_n = 1'b0, esc = 1'b0;
   logic rom_req; logic [AW-1:0] rom_addr; logic [31:0] rom_rdata = '0;
   logic hvalid, hlast, hready = 1'b0, hdone = 1'b0, herr = 1'b0;
   logic [63:0] hdata; logic [7:0] hstrb;
   logic [255:0] sh0 = '0, sh1 = '0, kdig;
   logic [3:0] pdone, pgood;
   logic kvalid, bsel, alert;
   logic [31:0] mem [ROM_WORDS];
   int n_chk = 0, n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   always_ff @(posedge clk) if (rom_req) rom_rdata <= mem[rom_addr];

   rom_check_seq #(.ROM_WORDS(ROM_WORDS)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .esc_i(esc), .rom_req_o(rom_req),
      .rom_addr_o(rom_addr), .rom_rdata_i(rom_rdata), .hash_valid_o(hvalid),
      .hash_data_o(hdata), .hash_strb_o(hstrb), .hash_last_o(hlast),
      .hash_ready_i(hready), .hash_done_i(hdone), .hash_share0_i(sh0),
      .hash_share1_i(sh1), .hash_err_i(herr), .pm_done_o(pdone),
      .pm_good_o(pgood), .km_valid_o(kvalid), .km_digest_o(kdig),
      .bus_sel_o(bsel), .alert_o(alert));

   task automatic chk(input bit ok, input string req, input logic [255:0] act,
                      input logic [255:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // mode 0 pass, 1 mismatch, 2 early hash done, 3 escalation, 4 error toggling + late done
   task automatic run(input int mode);
      logic [255:0] d, prev_dig;
      logic [7:0] lf;
      logic [63:0] prev_data;
      bit prev_v, prev_r, prev_last, prev_done, prev_alert, prev_kv, dead, exp_alert;
      bit got_last, fired, seen_done, late_fired;
      logic [3:0] prev_good;
      int k, cnt, tail;
      for (int i = 0; i < 8; i++) d[i*32 +: 32] = 32'h1357_9BDF * (i + 3) ^ 32'(mode);
      for (int i = 0; i < NDATA; i++) mem[i] = 32'h9E37_79B1 * (i + 1) ^ 32'(mode << 8);
      for (int i = 0; i < 8; i++) mem[NDATA+i] = d[i*32 +: 32];
      if (mode == 1) mem[NDATA+3] = mem[NDATA+3] ^ 32'h0000_0100;
      lf = 8'hA1 ^ 8'(mode);
      prev_v = 0; prev_r = 0; prev_last = 0; prev_data = '0; prev_done = 0;
      prev_alert = 0; prev_kv = 0; prev_dig = '0; prev_good = F4;
      dead = 0; exp_alert = 0; got_last = 0; fired = 0; seen_done = 0; late_fired = 0;
      k = 0; cnt = 0; tail = 0;
      rst_n = 0; esc = 0; hdone = 0; hready = 0; herr = 0;
      repeat (3) @(negedge clk);
      // R1: reset values while reset is held
      chk(pdone == F4 && pgood == F4 && !kvalid && !bsel && !alert && !hvalid,
          "R1 reset", {pdone, pgood, kvalid, bsel, alert, hvalid}, {F4, F4, 4'b0});
      rst_n = 1;
      for (int cyc = 0; cyc < 3000; cyc++) begin
         @(negedge clk);
         if (prev_done) begin
            chk(pdone == T4, "R7 done sticky", pdone, T4);
            chk(pgood == prev_good, "R7 good stable", pgood, prev_good);
            chk(bsel, "R7 bus select", bsel, 1);
         end
         if (prev_alert) chk(alert, "R10 alert sticky", alert, 1);
         if (prev_kv) chk(kvalid && kdig == prev_dig, "R5 digest held", kdig, prev_dig);
         if (prev_v && !prev_r && !dead)
            chk(hvalid && hdata == prev_data && hlast == prev_last, "R4 hold",
                {hvalid, hlast, hdata}, {1'b1, prev_last, prev_data});
         if (exp_alert) begin
            chk(alert && !hvalid, mode == 2 ? "R8 early done alert" : "R9 escalation alert",
                {alert, hvalid}, 2'b10);
            exp_alert = 0;
         end
         if (dead && !exp_alert) chk(!hvalid && pdone == F4, mode == 2 ? "R8 trapped" : "R9 trapped",
                                     {hvalid, pdone}, {1'b0, F4});
         hdone = 0; esc = 0;
         lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
         hready = lf[0] | lf[2];
         if (mode == 4) herr = lf[1]; // R11
         if (hvalid && hready && !dead) begin
            chk(hdata == {32'h0, mem[k]}, "R2 stream word", hdata, {32'h0, mem[k]});
            chk(hlast == (k == NDATA - 1), "R3 last flag", hlast, (k == NDATA - 1));
            chk(hstrb == 8'h0, "R3 strobe zero", hstrb, 0);
            if (k == NDATA - 1) got_last = 1;
            k++;
         end
         if (mode == 2 && k == 5 && !fired) begin
            hdone = 1; sh0 = {8{32'hDEAD_BEEF}}; sh1 = '0;
            fired = 1; exp_alert = 1; dead = 1;
         end
         if (mode == 3 && k == 10 && !fired) begin
            esc = 1; fired = 1; exp_alert = 1; dead = 1;
         end
         if (got_last && !fired) begin
            cnt++;
            if (cnt == 3) begin
               sh0 = {8{32'h5A5A_0F0F}} ^ 256'(mode);
               sh1 = d ^ sh0;
               hdone = 1; fired = 1;
            end
         end
         if (pdone == T4 && !seen_done) begin
            seen_done = 1;
            chk(kvalid && kdig == d, "R5 digest capture", kdig, d);
            chk(pgood == (mode == 1 ? F4 : T4), "R6 verdict", pgood, (mode == 1 ? F4 : T4));
            chk(bsel, "R7 handover", bsel, 1);
         end
         if (seen_done) begin
            tail++;
            if (mode == 4 && tail == 5 && !late_fired) begin
               late_fired = 1; hdone = 1; sh0 = '1; sh1 = '0; // R7 late pulse ignored
            end
         end
         prev_v = hvalid; prev_r = hready; prev_data = hdata; prev_last = hlast;
         prev_done = (pdone == T4); prev_good = pgood; prev_alert = alert;
         prev_kv = kvalid; prev_dig = kdig;
         if (tail == 25) break;
         if (dead && cyc > 200) break;
      end
      if (mode == 2 || mode == 3)
         chk(alert && !seen_done, mode == 2 ? "R8 no completion" : "R9 no completion",
             {alert, seen_done}, 2'b10);
      else
         chk(seen_done && !alert && pdone == T4, "R7 completion reached",
             {seen_done, alert, pdone}, {2'b10, T4});
   endtask

   initial begin : watchdog
      #(CLK_P * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      for (int m = 0; m < 5; m++) run(m);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule